// File: doc/BRIEF.md
# Out-of-order miss data pairing decoder

This block sits on the trace-analysis side of a processor trace path whose data cache can keep working past a load miss. For every load that misses, the trace stream first carries a placeholder packet (optionally with the load address). The loaded value comes later, in a separate returned-data packet that carries the same small tag. Several misses can be in flight, and their data can come back in any order. The block receives already-decoded packet descriptors, one per valid/ready handshake. For each tag it remembers the latest placeholder. It joins every returned-data packet to that placeholder and emits one resolved record of address and data.

A 64-bit load shows up as two placeholders with the same tag, one directly after the other. Its value returns as two same-tag data packets that are also adjacent. The block treats adjacency among accepted descriptors plus an equal tag as the sign of a pair. Packet timing plays no part. It merges such a pair into one 64-bit record. A returned-data packet with nothing pending on its tag is dropped, and the drop is flagged by a one-cycle pulse. This happens normally at the start of a capture. A placeholder that overwrites a still-pending one is counted.

Top module: `miss_pair_decoder`

## Requirements
- R1: In the cycle after a synchronous reset, `out_valid` and `out_unexpected` are low and `replace_count` is zero. `in_ready` is low during reset and goes high from the first clock edge at which reset is released.
- R2: A descriptor is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_kind` values: 2'b01 is a placeholder, 2'b10 is returned data, and 2'b00 and 2'b11 are other traffic that changes no pending state.
- R3: When a returned-data packet's tag has a pending single-width placeholder, exactly one record appears in the cycle after acceptance. The record carries the placeholder's address and address-valid flag, `out_data[31:0]` equal to the data, zero upper bits and `out_wide` low. The tag is then no longer pending.
- R4: Matching uses only the tag. Returns may arrive in any order relative to their placeholders, with other accepted descriptors in between, and each gets the address of the latest placeholder on its own tag.
- R5: A returned-data packet whose tag has nothing pending produces no record. Instead, `out_unexpected` is high for exactly the one cycle after acceptance. `out_valid` and `out_unexpected` are never high together.
- R6: A placeholder that opens an entry on a tag that is already pending replaces that entry with its own address. `replace_count` rises by exactly one in the cycle after acceptance and changes at no other time.
- R7: A placeholder accepted directly after a placeholder that opened an entry on the same tag marks that entry 64-bit. Its own address fields are ignored, so the first address is kept. A third same-tag placeholder in a row opens a new entry, which counts as a replacement.
- R8: Two same-tag placeholders separated by any other accepted descriptor are not a pair. The second one replaces the first.
- R9: For a pending 64-bit entry, the first matching data packet produces no record. If the next accepted descriptor is a data packet on the same tag, one record follows one cycle later with `out_data` = {second, first}, `out_wide` high and the first placeholder's address.
- R10: If a held first half is followed by any accepted descriptor other than same-tag data, the held half is dropped. No record and no unexpected pulse are produced. A later data packet on that tag counts as unexpected.
- R11: Cycles with `in_valid` low are not descriptors. They do not break the adjacency that pairs placeholders or data halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be taken |
| in_kind | input | 2 | Descriptor kind (01 placeholder, 10 data, else other) |
| in_tag | input | TAG_W (2) | Miss tag |
| in_addr_valid | input | 1 | Placeholder carries an address |
| in_addr | input | ADDR_W (32) | Placeholder address |
| in_data | input | DATA_W (32) | Returned data word |
| out_valid | output | 1 | Resolved record present (one cycle) |
| out_tag | output | TAG_W (2) | Tag of the record |
| out_addr_valid | output | 1 | Record address is meaningful |
| out_addr | output | ADDR_W (32) | Address from the matched placeholder |
| out_data | output | 2*DATA_W (64) | Data; upper half zero for single-width |
| out_wide | output | 1 | Record is a 64-bit value |
| out_unexpected | output | 1 | Unmatched data packet was dropped |
| replace_count | output | CNT_W (8) | Wrapping count of replaced pending entries |

## Verification
The assertions assume that every descriptor is accepted only under the handshake and that a table operation on a tag acts on the pending state that the lookup just reported. They also assume that a 64-bit record can only come from a half held on the previous acceptance. The stimulus gives every descriptor a legal kind code and drives the tag and address fields only while `in_valid` is high, with random idle gaps. It mixes directed sequences for each pairing corner case with a long random run. The random run deliberately repeats the previous kind and tag often, so that pairs, triples and interrupted halves occur frequently.

// File: rtl/miss_pair_pkg.sv
// Shared types for the miss pairing decoder.
// Assumes: kind codes are fixed by the upstream packet decoder.
package miss_pair_pkg;
    typedef enum logic [1:0] {
        K_OTHER = 2'b00,
        K_PLACE = 2'b01,
        K_DATA  = 2'b10,
        K_RSVD  = 2'b11
    } pkt_kind_e;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_INSTALL = 2'b01,
        OP_WIDEN   = 2'b10,
        OP_CLEAR   = 2'b11
    } tbl_op_e;
endpackage

// File: rtl/miss_pend_table.sv
// Pending-miss table: one entry per tag value, each holding the entry's
// valid, address-valid, address and 64-bit flag.
// Assumes: at most one operation per cycle, always on the looked-up tag.
module miss_pend_table
    import miss_pair_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_valid,
    output logic              lk_addr_valid,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              lk_wide,
    input  tbl_op_e           op,
    input  logic              op_addr_valid,
    input  logic [ADDR_W-1:0] op_addr
);
    localparam int ENTRIES = 1 << TAG_W;

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_av;
    logic [ENTRIES-1:0] ent_wide;
    logic [ADDR_W-1:0]  ent_addr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic hit;
        assign hit = (lk_tag == TAG_W'(g));

        // Apply this cycle's table operation when it targets this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_av[g]    <= 1'b0;
                ent_wide[g]  <= 1'b0;
                ent_addr[g]  <= '0;
            end else if (hit) begin
                case (op)
                    OP_INSTALL: begin
                        ent_valid[g] <= 1'b1;
                        ent_av[g]    <= op_addr_valid;
                        ent_wide[g]  <= 1'b0;
                        ent_addr[g]  <= op_addr;
                    end
                    OP_WIDEN: ent_wide[g]  <= 1'b1;
                    OP_CLEAR: ent_valid[g] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // Combinational read of the entry named by the incoming tag.
    always_comb begin
        lk_valid      = ent_valid[lk_tag];
        lk_addr_valid = ent_av[lk_tag];
        lk_wide       = ent_wide[lk_tag];
        lk_addr       = ent_addr[lk_tag];
    end

    assert_widen_on_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WIDEN) |-> lk_valid);
    assert_clear_on_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |-> lk_valid);
endmodule

// File: rtl/miss_replace_counter.sv
// Wrapping counter of pending entries overwritten by a new placeholder.
// Assumes: inc is a single-cycle strobe per replacement.
module miss_replace_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Step the count on every replacement strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + 1'b1));
endmodule

// File: rtl/miss_pair_ctrl.sv
// Pairing control: tracks adjacency of accepted descriptors, picks the
// table operation, holds the first half of a 64-bit return and registers
// the output record and the unexpected pulse.
// Assumes: table lookup is presented on the same tag as the descriptor.
module miss_pair_ctrl
    import miss_pair_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_kind,
    input  logic [TAG_W-1:0]    in_tag,
    input  logic                in_addr_valid,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                lk_valid,
    input  logic                lk_addr_valid,
    input  logic [ADDR_W-1:0]   lk_addr,
    input  logic                lk_wide,
    output tbl_op_e             op,
    output logic                replace,
    output logic                out_valid,
    output logic [TAG_W-1:0]    out_tag,
    output logic                out_addr_valid,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [2*DATA_W-1:0] out_data,
    output logic                out_wide,
    output logic                out_unexpected
);
    pkt_kind_e          kind;
    logic               accept;
    logic               prev_open;
    logic [TAG_W-1:0]   prev_tag;
    logic               hold_v;
    logic [TAG_W-1:0]   hold_tag;
    logic               hold_av;
    logic [ADDR_W-1:0]  hold_addr;
    logic [DATA_W-1:0]  hold_lo;
    logic               pair_ph;
    logic               second_half;
    logic               emit;
    logic               emit_wide;
    logic               unexp;
    logic               start_hold;

    assign kind   = pkt_kind_e'(in_kind);
    assign accept = in_valid && in_ready;

    // Decide the table operation and the record for the accepted descriptor.
    always_comb begin
        op          = OP_NONE;
        replace     = 1'b0;
        emit        = 1'b0;
        emit_wide   = 1'b0;
        unexp       = 1'b0;
        start_hold  = 1'b0;
        pair_ph     = accept && (kind == K_PLACE) && prev_open && (prev_tag == in_tag);
        second_half = accept && (kind == K_DATA) && hold_v && (hold_tag == in_tag);
        if (accept) begin
            case (kind)
                K_PLACE: begin
                    if (pair_ph) begin
                        op = OP_WIDEN;
                    end else begin
                        op      = OP_INSTALL;
                        replace = lk_valid;
                    end
                end
                K_DATA: begin
                    if (second_half) begin
                        emit      = 1'b1;
                        emit_wide = 1'b1;
                    end else if (lk_valid) begin
                        op = OP_CLEAR;
                        if (lk_wide) start_hold = 1'b1;
                        else         emit       = 1'b1;
                    end else begin
                        unexp = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Ready rises one edge after reset release and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Track whether the last accepted descriptor opened a placeholder entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_open <= 1'b0;
            prev_tag  <= '0;
        end else if (accept) begin
            prev_open <= (kind == K_PLACE) && !pair_ph;
            prev_tag  <= in_tag;
        end
    end

    // Hold the first half of a 64-bit return for exactly one acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_tag  <= '0;
            hold_av   <= 1'b0;
            hold_addr <= '0;
            hold_lo   <= '0;
        end else if (accept) begin
            hold_v <= start_hold;
            if (start_hold) begin
                hold_tag  <= in_tag;
                hold_av   <= lk_addr_valid;
                hold_addr <= lk_addr;
                hold_lo   <= in_data;
            end
        end
    end

    // Register the resolved record and the unexpected pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_unexpected <= 1'b0;
            out_tag        <= '0;
            out_addr_valid <= 1'b0;
            out_addr       <= '0;
            out_data       <= '0;
            out_wide       <= 1'b0;
        end else begin
            out_valid      <= emit;
            out_unexpected <= unexp;
            if (emit) begin
                out_tag        <= in_tag;
                out_wide       <= emit_wide;
                out_addr_valid <= emit_wide ? hold_av   : lk_addr_valid;
                out_addr       <= emit_wide ? hold_addr : lk_addr;
                out_data       <= emit_wide ? {in_data, hold_lo}
                                            : {{DATA_W{1'b0}}, in_data};
            end
        end
    end

    assert_record_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_unexpected));
    assert_unexp_follows_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_unexpected |-> $past(accept && (kind == K_DATA)));
    assert_record_follows_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(accept && (kind == K_DATA)));
    assert_wide_needs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wide) |-> $past(hold_v));
    assert_no_accept_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !in_ready);
endmodule

// File: rtl/miss_pair_decoder.sv
// Top of the out-of-order miss pairing decoder: joins returned-data
// descriptors to the latest same-tag placeholder and emits records.
// Assumes: descriptors are already decoded from the byte stream.
module miss_pair_decoder
    import miss_pair_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_kind,
    input  logic [TAG_W-1:0]    in_tag,
    input  logic                in_addr_valid,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    output logic [TAG_W-1:0]    out_tag,
    output logic                out_addr_valid,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [2*DATA_W-1:0] out_data,
    output logic                out_wide,
    output logic                out_unexpected,
    output logic [CNT_W-1:0]    replace_count
);
    logic              lk_valid;
    logic              lk_addr_valid;
    logic [ADDR_W-1:0] lk_addr;
    logic              lk_wide;
    tbl_op_e           op;
    logic              replace;

    miss_pend_table #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_tag        (in_tag),
        .lk_valid      (lk_valid),
        .lk_addr_valid (lk_addr_valid),
        .lk_addr       (lk_addr),
        .lk_wide       (lk_wide),
        .op            (op),
        .op_addr_valid (in_addr_valid),
        .op_addr       (in_addr)
    );

    miss_pair_ctrl #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_kind        (in_kind),
        .in_tag         (in_tag),
        .in_addr_valid  (in_addr_valid),
        .in_addr        (in_addr),
        .in_data        (in_data),
        .lk_valid       (lk_valid),
        .lk_addr_valid  (lk_addr_valid),
        .lk_addr        (lk_addr),
        .lk_wide        (lk_wide),
        .op             (op),
        .replace        (replace),
        .out_valid      (out_valid),
        .out_tag        (out_tag),
        .out_addr_valid (out_addr_valid),
        .out_addr       (out_addr),
        .out_data       (out_data),
        .out_wide       (out_wide),
        .out_unexpected (out_unexpected)
    );

    miss_replace_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (replace),
        .count (replace_count)
    );
endmodule

// File: tb/miss_pair_decoder_bench.sv
module miss_pair_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'b00;
    logic [1:0]  in_tag = '0;
    logic        in_addr_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [1:0]  out_tag;
    logic        out_addr_valid;
    logic [31:0] out_addr;
    logic [63:0] out_data;
    logic        out_wide;
    logic        out_unexpected;
    logic [7:0]  replace_count;

    always #5 clk = ~clk;

    miss_pair_decoder u_miss_pair_decoder (.*);

    int    tests = 0;
    int    fails = 0;
    string scen  = "R1";
    bit    started = 0;

    // Behavioural reference state
    bit          m_ready;
    bit          p_v [4];
    bit          p_av [4];
    bit          p_w [4];
    int unsigned p_a [4];
    bit          last_open;
    int          last_tag;
    bit          h_v;
    int          h_tag;
    bit          h_av;
    int unsigned h_a;
    int unsigned h_lo;
    int          m_rep;
    bit          e_valid, e_unexp, e_av, e_wide;
    int          e_tag;
    int unsigned e_addr;
    logic [63:0] e_data;
    string       e_req;

    // Reference model: one update per clock edge
    always @(posedge clk) begin
        bit pair, keep_hold;
        e_valid = 0; e_unexp = 0; e_req = scen;
        if (!rst_n) begin
            m_ready = 0; last_open = 0; last_tag = 0; h_v = 0; m_rep = 0;
            for (int i = 0; i < 4; i++) begin p_v[i] = 0; p_w[i] = 0; end
        end else begin
            if (in_valid && m_ready) begin
                keep_hold = 0;
                if (in_kind == 2'b01) begin
                    pair = last_open && (last_tag == in_tag);
                    if (pair) begin
                        p_w[in_tag] = 1;      // R7 second placeholder widens
                        last_open = 0;
                    end else begin
                        if (p_v[in_tag]) m_rep = (m_rep + 1) % 256;  // R6
                        p_v[in_tag] = 1; p_av[in_tag] = in_addr_valid;
                        p_a[in_tag] = in_addr; p_w[in_tag] = 0;
                        last_open = 1;
                    end
                end else begin
                    last_open = 0;
                    if (in_kind == 2'b10) begin
                        if (h_v && h_tag == in_tag) begin
                            e_valid = 1; e_wide = 1; e_tag = in_tag; e_av = h_av;
                            e_addr = h_a; e_data = {in_data, h_lo}; e_req = "R9";
                        end else if (p_v[in_tag]) begin
                            p_v[in_tag] = 0;
                            if (p_w[in_tag]) begin
                                keep_hold = 1; h_tag = in_tag; h_av = p_av[in_tag];
                                h_a = p_a[in_tag]; h_lo = in_data;
                            end else begin
                                e_valid = 1; e_wide = 0; e_tag = in_tag;
                                e_av = p_av[in_tag]; e_addr = p_a[in_tag];
                                e_data = {32'h0, in_data}; e_req = "R3";
                            end
                        end else begin
                            e_unexp = 1; e_req = "R5";
                        end
                    end
                end
                h_v = keep_hold;
                last_tag = in_tag;
            end
            m_ready = 1;
        end
        started = 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare against the reference away from the active edge
    always @(negedge clk) if (started) begin
        chk(in_ready == m_ready, "R1", "in_ready", 64'(in_ready), 64'(m_ready));
        chk(out_valid == e_valid, e_req, "out_valid", 64'(out_valid), 64'(e_valid));
        chk(out_unexpected == e_unexp, e_req, "out_unexpected",
            64'(out_unexpected), 64'(e_unexp));
        chk(replace_count == 8'(m_rep), "R6", "replace_count",
            64'(replace_count), 64'(m_rep));
        if (e_valid && out_valid) begin
            chk(out_data == e_data, e_req, "out_data", out_data, e_data);
            chk(out_addr == e_addr && out_addr_valid == e_av && out_wide == e_wide
                && out_tag == 2'(e_tag), e_req, "record addr/flags",
                {out_addr, 29'h0, out_addr_valid, out_wide, 1'b0},
                {e_addr, 29'h0, e_av, e_wide, 1'b0});
        end
    end

    // Drive one descriptor for one cycle, then optional idle cycles
    task automatic send(input logic [1:0] k, input int t, input bit av,
                        input int unsigned a, input int unsigned d, input int idle);
        @(negedge clk);
        in_valid = 1; in_kind = k; in_tag = 2'(t);
        in_addr_valid = av; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 0; in_addr_valid = 0; in_addr = 'x; in_data = 'x;
        repeat (idle) @(negedge clk);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!out_valid && !out_unexpected && replace_count == 0 && !in_ready,
            "R1", "reset outputs", {out_valid, out_unexpected, in_ready}, 0);
        rst_n = 1;
        gap(2);
        // R3 single match; R2 other-traffic codes 00 and 11 change nothing
        scen = "R3";
        send(2'b01, 1, 1, 32'h1000_0040, 0, 0);
        scen = "R2";
        send(2'b00, 1, 0, 0, 0, 0);
        send(2'b11, 1, 1, 32'hdead, 0, 0);
        scen = "R3";
        send(2'b10, 1, 0, 0, 32'hcafe_0001, 2);
        // R4 out-of-order returns with traffic between
        scen = "R4";
        send(2'b01, 0, 1, 32'h2000, 0, 0);
        send(2'b01, 2, 0, 32'h0, 0, 0);
        send(2'b00, 3, 0, 0, 0, 0);
        send(2'b10, 2, 0, 0, 32'h22, 0);
        send(2'b10, 0, 0, 0, 32'h11, 2);
        // R5 unmatched data
        scen = "R5";
        send(2'b10, 3, 0, 0, 32'h33, 2);
        // R6 replacement
        scen = "R6";
        send(2'b01, 1, 1, 32'hA000, 0, 0);
        send(2'b00, 0, 0, 0, 0, 0);
        send(2'b01, 1, 1, 32'hB000, 0, 0);
        send(2'b10, 1, 0, 0, 32'h66, 2);
        // R8 same tag separated by another placeholder
        scen = "R8";
        send(2'b01, 0, 1, 32'hC000, 0, 0);
        send(2'b01, 1, 1, 32'hC100, 0, 0);
        send(2'b01, 0, 1, 32'hC200, 0, 0);
        send(2'b10, 0, 0, 0, 32'h88, 0);
        send(2'b10, 1, 0, 0, 32'h89, 2);
        // R7 / R9 wide pair, second address ignored
        scen = "R7";
        send(2'b01, 2, 1, 32'hD000, 0, 0);
        send(2'b01, 2, 1, 32'hFFFF, 0, 0);
        scen = "R9";
        send(2'b10, 2, 0, 0, 32'h0000_1111, 0);
        send(2'b10, 2, 0, 0, 32'h2222_0000, 2);
        // R7 triple placeholder opens new entry
        scen = "R7";
        send(2'b01, 3, 1, 32'hE000, 0, 0);
        send(2'b01, 3, 0, 0, 0, 0);
        send(2'b01, 3, 1, 32'hE100, 0, 0);
        send(2'b10, 3, 0, 0, 32'h77, 2);
        // R10 interrupted half, then late data is unexpected
        scen = "R10";
        send(2'b01, 1, 1, 32'hF000, 0, 0);
        send(2'b01, 1, 0, 0, 0, 0);
        send(2'b10, 1, 0, 0, 32'h5, 0);
        send(2'b00, 0, 0, 0, 0, 0);
        send(2'b10, 1, 0, 0, 32'h6, 2);
        // R11 idle cycles inside pairs
        scen = "R11";
        send(2'b01, 0, 1, 32'h9000, 0, 5);
        send(2'b01, 0, 0, 0, 0, 3);
        send(2'b10, 0, 0, 0, 32'haaaa, 4);
        send(2'b10, 0, 0, 0, 32'hbbbb, 2);
        // Random mix biased towards repeats (R4 R7 R9 R10)
        scen = "R4";
        begin
            logic [1:0] lk = 2'b01;
            int lt = 0;
            for (int n = 0; n < 4000; n++) begin
                int r = $urandom_range(0, 99);
                if (r >= 35) begin
                    lk = 2'($urandom_range(0, 3));
                    if (lk == 2'b11 && $urandom_range(0, 1) == 1) lk = 2'b10;
                    lt = $urandom_range(0, 3);
                end
                send(lk, lt, 1'($urandom_range(0, 1)), $urandom, $urandom,
                     $urandom_range(0, 2));
            end
        end
        gap(3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule